// File: doc/BRIEF.md
# Power-Management Event Status and System Control Interrupt Block

This block collects the fixed power-management wake and notification events of a chip: the real-time-clock alarm, the power button, the global-lock release and an overflow of the free-running power-management timer. Each event sets a sticky status bit. A register port gives software access to the status, enable and control words and to the timer count. Software acknowledges an event by writing a one to its status bit. One general-purpose hotplug event has its own sticky status bit, which the `evt_hotplug` pulse sets and the `gpe_hp_clr` pulse clears, and an enable level `gpe_hp_en`.

The block drives a level-sensitive system control interrupt. The interrupt is high while any enabled fixed event or the enabled hotplug event is pending. A small arming state machine watches the timer. It has three states: `ARM_OFF`, where the timer enable is clear and the reference copy of the counter's top bit follows the counter; `ARM_WATCH`, where the reference is frozen and a change of the top bit raises the timer status; and `ARM_FIRED`, where the status is set and the machine waits for software to clear it.

The transitions are: `ARM_OFF`→`ARM_WATCH` when the timer enable becomes set; `ARM_WATCH`→`ARM_OFF` when it is cleared; `ARM_WATCH`→`ARM_FIRED` on a top-bit change; `ARM_FIRED`→`ARM_WATCH` or `ARM_OFF`, according to the enable, when software clears the timer status. In that last transition the reference is captured again from the current count.

Top module: `pm_event_ctrl`

## Requirements
- R1: The read data is combinational on `reg_addr`. Offset 0x0 returns the status word, 0x2 the enable word, 0x4 the control word, and 0x8 the timer count zero-extended. A write to 0x2 or 0x4 stores all 16 data bits. Status bits other than 0, 5, 8 and 10 always read 0.
- R2: A read at any offset other than 0x0, 0x2, 0x4 and 0x8 returns zero.
- R3: A write to offset 0x0 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R4: The one-cycle pulses `evt_rtc`, `evt_pwrbtn` and `evt_glock` set status bits 10, 8 and 5. A set and a clear of the same bit in the same cycle leave the bit set.
- R5: The timer counter advances by one on each clock that has `tick_en` high, and holds otherwise.
- R6: Timer status (bit 0) is set only while timer enable (enable bit 0) is 1 and the status is clear. It is set when the counter's top bit differs from the reference captured when the watch began.
- R7: Clearing a set timer status captures the reference again from the current count. The status therefore sets again only after the next change of the top bit.
- R8: `sci` is registered. It is high one clock after any of status bits 0, 5, 8 or 10 is 1 together with the enable bit at the same position, and low one clock after none is.
- R9: The `evt_hotplug` pulse sets a hotplug status bit and the `gpe_hp_clr` pulse clears it; if both arrive in the same cycle, the bit is set. `sci` is also high one clock after this bit and `gpe_hp_en` are both 1.
- R10: After reset, every register, the counter and `sci` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (4) | Register offset |
| reg_wdata | input | REG_W (16) | Write data |
| reg_rdata | output | RD_W (32) | Read data for `reg_addr` |
| tick_en | input | 1 | Timer advance enable |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | Real-time-clock alarm pulse |
| evt_glock | input | 1 | Global-lock release pulse |
| evt_hotplug | input | 1 | Hotplug event pulse |
| gpe_hp_en | input | 1 | Hotplug interrupt enable |
| gpe_hp_clr | input | 1 | Hotplug status clear pulse |
| sci | output | 1 | System control interrupt, level |

## Verification
The bench builds the block with `TMR_W = 8`. The counter's top bit then changes every 128 ticks instead of every 2^23 ticks. This puts the first timer overflow, the clear and re-arm, and the wrap of the counter back through zero within a few hundred cycles. The bench reads the count back through offset 0x8 and computes the exact tick at which the status must set. It checks the status one tick before that point and again just after it.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;
    localparam int STS_TMR = 0;
    localparam int STS_GBL = 5;
    localparam int STS_PWR = 8;
    localparam int STS_RTC = 10;

    localparam logic [3:0] OFS_STS = 4'h0;
    localparam logic [3:0] OFS_EN  = 4'h2;
    localparam logic [3:0] OFS_CTL = 4'h4;
    localparam logic [3:0] OFS_TMR = 4'h8;

    typedef enum logic [1:0] {
        ARM_OFF   = 2'd0,
        ARM_WATCH = 2'd1,
        ARM_FIRED = 2'd2
    } arm_state_t;
endpackage

// File: rtl/pm_tick_counter.sv
module pm_tick_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (tick_en) count <= count + 1'b1;
    end

    // R5
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick_en) |-> count == W'($past(count) + 1'b1));
    // R5
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick_en) |-> $stable(count));
endmodule

// File: rtl/pm_ovf_arm.sv
module pm_ovf_arm
    import pm_event_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msb,
    input  logic tmr_en,
    input  logic tmr_sts,
    input  logic tmr_clr,
    output logic ovf_set
);
    arm_state_t state, state_nx;
    logic       ref_msb, ref_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ARM_OFF;
            ref_msb <= 1'b0;
        end else begin
            state   <= state_nx;
            ref_msb <= ref_nx;
        end
    end

    always_comb begin
        state_nx = state;
        ref_nx   = ref_msb;
        ovf_set  = 1'b0;
        unique case (state)
            ARM_OFF: begin
                ref_nx = msb;
                if (tmr_en) state_nx = ARM_WATCH;
            end
            ARM_WATCH: begin
                if (!tmr_en) begin
                    state_nx = ARM_OFF;
                end else if (msb != ref_msb) begin
                    ovf_set  = 1'b1;
                    state_nx = ARM_FIRED;
                end
            end
            ARM_FIRED: begin
                if (tmr_clr) begin
                    ref_nx   = msb;
                    state_nx = tmr_en ? ARM_WATCH : ARM_OFF;
                end
            end
            default: state_nx = ARM_OFF;
        endcase
    end

    // R6
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |-> tmr_en && !tmr_sts);
    // R7
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ARM_FIRED && tmr_clr |=> !ovf_set);
endmodule

// File: rtl/pm_status_regs.sv
module pm_status_regs
    import pm_event_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_vec,
    input  logic             hp_set,
    input  logic             hp_clr,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic [REG_W-1:0] ctl,
    output logic             hp_sts,
    output logic             tmr_clr
);
    localparam logic [REG_W-1:0] IMPL =
        (REG_W'(1) << STS_TMR) | (REG_W'(1) << STS_GBL) |
        (REG_W'(1) << STS_PWR) | (REG_W'(1) << STS_RTC);

    logic [REG_W-1:0] clr_vec;
    assign clr_vec = wr_sts ? wdata : '0;
    assign tmr_clr = clr_vec[STS_TMR] & sts[STS_TMR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts    <= '0;
            en     <= '0;
            ctl    <= '0;
            hp_sts <= 1'b0;
        end else begin
            sts    <= ((sts & ~clr_vec) | set_vec) & IMPL;
            hp_sts <= (hp_sts & ~hp_clr) | hp_set;
            if (wr_en)  en  <= wdata;
            if (wr_ctl) ctl <= wdata;
        end
    end

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec & ~set_vec) != '0 |=> (sts & $past(clr_vec & ~set_vec)) == '0);
    // R3
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && set_vec == '0 && $past(set_vec) == '0 |=> (sts & ~$past(clr_vec)) == ($past(sts) & ~$past(clr_vec)));
    // R4
    set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec & IMPL) != '0 |=> (sts & $past(set_vec & IMPL)) == $past(set_vec & IMPL));
    // R9
    hp_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_set |=> hp_sts);
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
    import pm_event_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sts,
    input  logic [REG_W-1:0] en,
    input  logic             hp_sts,
    input  logic             hp_en,
    output logic             sci
);
    localparam logic [REG_W-1:0] SCI_SRC =
        (REG_W'(1) << STS_TMR) | (REG_W'(1) << STS_GBL) |
        (REG_W'(1) << STS_PWR) | (REG_W'(1) << STS_RTC);

    logic fixed_hit;
    assign fixed_hit = |(sts & en & SCI_SRC);

    always_ff @(posedge clk) begin
        if (!rst_n) sci <= 1'b0;
        else        sci <= fixed_hit | (hp_sts & hp_en);
    end
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_event_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int TMR_W  = 24,
    parameter int RD_W   = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    input  logic              tick_en,
    input  logic              evt_pwrbtn,
    input  logic              evt_rtc,
    input  logic              evt_glock,
    input  logic              evt_hotplug,
    input  logic              gpe_hp_en,
    input  logic              gpe_hp_clr,
    output logic              sci
);
    logic [TMR_W-1:0] count;
    logic [REG_W-1:0] sts, en, ctl, set_vec;
    logic             hp_sts, tmr_clr, ovf_set;
    logic             wr_sts, wr_en, wr_ctl;

    assign wr_sts = reg_wr && reg_addr == ADDR_W'(OFS_STS);
    assign wr_en  = reg_wr && reg_addr == ADDR_W'(OFS_EN);
    assign wr_ctl = reg_wr && reg_addr == ADDR_W'(OFS_CTL);

    always_comb begin
        set_vec          = '0;
        set_vec[STS_TMR] = ovf_set;
        set_vec[STS_GBL] = evt_glock;
        set_vec[STS_PWR] = evt_pwrbtn;
        set_vec[STS_RTC] = evt_rtc;
    end

    pm_tick_counter #(.W(TMR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count));

    pm_ovf_arm u_arm (
        .clk(clk), .rst_n(rst_n), .msb(count[TMR_W-1]),
        .tmr_en(en[STS_TMR]), .tmr_sts(sts[STS_TMR]),
        .tmr_clr(tmr_clr), .ovf_set(ovf_set));

    pm_status_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wr_en(wr_en),
        .wr_ctl(wr_ctl), .wdata(reg_wdata), .set_vec(set_vec),
        .hp_set(evt_hotplug), .hp_clr(gpe_hp_clr), .sts(sts), .en(en),
        .ctl(ctl), .hp_sts(hp_sts), .tmr_clr(tmr_clr));

    pm_sci_gen #(.REG_W(REG_W)) u_sci (
        .clk(clk), .rst_n(rst_n), .sts(sts), .en(en),
        .hp_sts(hp_sts), .hp_en(gpe_hp_en), .sci(sci));

    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_STS): reg_rdata = RD_W'(sts);
            ADDR_W'(OFS_EN):  reg_rdata = RD_W'(en);
            ADDR_W'(OFS_CTL): reg_rdata = RD_W'(ctl);
            ADDR_W'(OFS_TMR): reg_rdata = RD_W'(count);
            default:          reg_rdata = '0;
        endcase
    end

    // R2
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr != ADDR_W'(OFS_STS) && reg_addr != ADDR_W'(OFS_EN) &&
        reg_addr != ADDR_W'(OFS_CTL) && reg_addr != ADDR_W'(OFS_TMR) |-> reg_rdata == '0);
    // R8
    sci_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[STS_RTC] && en[STS_RTC]) || (sts[STS_PWR] && en[STS_PWR]) ||
        (sts[STS_GBL] && en[STS_GBL]) || (sts[STS_TMR] && en[STS_TMR]) |=> sci);
    // R9
    sci_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_sts && gpe_hp_en |=> sci);
    // R6
    tmr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(sts[STS_TMR]) |-> $past(en[STS_TMR]));
endmodule

// File: tb/sim_pm_event_ctrl.sv
module sim_pm_event_ctrl;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_en = 1'b0;
    logic        evt_pwrbtn = 1'b0, evt_rtc = 1'b0, evt_glock = 1'b0;
    logic        evt_hotplug = 1'b0, gpe_hp_en = 1'b0, gpe_hp_clr = 1'b0;
    logic        sci;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    pm_event_ctrl #(.REG_W(16), .TMR_W(TW), .RD_W(32), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
        .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .evt_glock(evt_glock),
        .evt_hotplug(evt_hotplug), .gpe_hp_en(gpe_hp_en),
        .gpe_hp_clr(gpe_hp_clr), .sci(sci));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R10 reset read", d, 32'h0);
        end
        check("R10 reset sci", {31'b0, sci}, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        wr(4'h2, 16'h0000);
        wr(4'h4, 16'hA5C3);
        rd(4'h4, d); check("R1 control readback", d, 32'h0000A5C3);
        wr(4'h2, 16'hF0F0);
        rd(4'h2, d); check("R1 enable readback", d, 32'h0000F0F0);
        wr(4'h2, 16'h0000);
        @(negedge clk); evt_rtc = 1; evt_glock = 1;
        @(negedge clk); evt_rtc = 0; evt_glock = 0;
        rd(4'h0, d); check("R4 rtc+glock set bits 10,5", d, 32'h00000420);
        rd(4'h1, d); check("R2 offset 0x1 zero", d, 32'h0);
        rd(4'h3, d); check("R2 offset 0x3 zero", d, 32'h0);
        rd(4'h6, d); check("R2 offset 0x6 zero", d, 32'h0);
        rd(4'hF, d); check("R2 offset 0xF zero", d, 32'h0);
        wr(4'h0, 16'hFBDF);
        rd(4'h0, d); check("R1 unimplemented status bits zero", d, 32'h00000420);
        wr(4'h0, 16'h0400);
        rd(4'h0, d); check("R3 clear bit10 keeps bit5", d, 32'h00000020);
        wr(4'h0, 16'h0020);
        rd(4'h0, d); check("R3 clear bit5", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        evt_pwrbtn = 1; reg_wr = 1; reg_addr = 4'h0; reg_wdata = 16'h0100;
        @(negedge clk);
        evt_pwrbtn = 0; reg_wr = 0;
        rd(4'h0, d); check("R4 set wins over clear", d, 32'h00000100);
        wr(4'h0, 16'h0100);
        rd(4'h0, d); check("R3 pwrbtn cleared", d, 32'h0);
    endtask

    task automatic t_counter();
        logic [31:0] a, b;
        rd(4'h8, a);
        ticks(5);
        rd(4'h8, b); check("R5 counter +5", b, 32'((a + 5) % 256));
        repeat (3) @(negedge clk);
        rd(4'h8, a); check("R5 counter holds", a, b);
    endtask

    task automatic t_sci_fixed();
        logic [31:0] d;
        @(negedge clk); evt_rtc = 1;
        @(negedge clk); evt_rtc = 0;
        @(negedge clk);
        check("R8 sci low while rtc disabled", {31'b0, sci}, 32'h0);
        @(negedge clk);
        reg_wr = 1; reg_addr = 4'h2; reg_wdata = 16'h0400;
        @(negedge clk); reg_wr = 0;
        check("R8 sci not yet high", {31'b0, sci}, 32'h0);
        @(negedge clk);
        check("R8 sci high one clock later", {31'b0, sci}, 32'h1);
        wr(4'h0, 16'h0400);
        @(negedge clk);
        check("R8 sci low after clear", {31'b0, sci}, 32'h0);
        wr(4'h2, 16'h0000);
        rd(4'h0, d);
    endtask

    task automatic t_hotplug();
        @(negedge clk); evt_hotplug = 1;
        @(negedge clk); evt_hotplug = 0;
        @(negedge clk);
        check("R9 hotplug disabled no sci", {31'b0, sci}, 32'h0);
        gpe_hp_en = 1;
        @(negedge clk);
        @(negedge clk);
        check("R9 hotplug enabled sci", {31'b0, sci}, 32'h1);
        evt_hotplug = 1; gpe_hp_clr = 1;
        @(negedge clk); evt_hotplug = 0; gpe_hp_clr = 0;
        @(negedge clk);
        check("R9 hotplug set wins", {31'b0, sci}, 32'h1);
        gpe_hp_clr = 1;
        @(negedge clk); gpe_hp_clr = 0;
        @(negedge clk);
        check("R9 hotplug cleared", {31'b0, sci}, 32'h0);
        gpe_hp_en = 0;
    endtask

    task automatic t_timer();
        logic [31:0] c, d;
        int n;
        rd(4'h8, c);
        n = 128 - int'(c);
        ticks(300);
        rd(4'h0, d); check("R6 no timer status while disabled", d, 32'h0);
        rd(4'h8, c);
        if (c >= 128) begin ticks(256 - int'(c)); rd(4'h8, c); end
        n = 128 - int'(c);
        wr(4'h2, 16'h0001);
        ticks(n - 1);
        rd(4'h0, d); check("R6 timer status clear before toggle", d, 32'h0);
        ticks(2);
        rd(4'h0, d); check("R6 timer status set after toggle", d, 32'h1);
        check("R8 sci from timer", {31'b0, sci}, 32'h1);
        wr(4'h0, 16'h0001);
        rd(4'h0, d); check("R7 timer status cleared", d, 32'h0);
        rd(4'h8, c);
        n = 256 - int'(c);
        ticks(n - 1);
        rd(4'h0, d); check("R7 no refire before next toggle", d, 32'h0);
        ticks(2);
        rd(4'h0, d); check("R7 refire after wrap", d, 32'h1);
        wr(4'h2, 16'h0000);
        wr(4'h0, 16'h0001);
        rd(4'h0, d); check("R3 timer status cleared", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_set_wins();
        t_counter();
        t_sci_fixed();
        t_hotplug();
        t_timer();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule